// File: doc/BRIEF.md
# Sound Carrier Level Control Loop

This block holds the amplitude of a sampled sound carrier at a level the host chooses. It multiplies each incoming signed sample by a gain and saturates the product to the output width. It then takes the peak magnitude of the scaled samples over a fixed window of valid samples and moves the gain by one step toward the selected target level. The gain is a logarithmic code that the host can read back at any time and can overwrite. After a write the loop carries on regulating from the written value.

A 2-bit select picks one of four target levels. A mode input picks the loop speed. The fast speed suits carriers that hold their amplitude (FM or digital sound), and the gain may then move after every window. The slow speed suits amplitude-modulated sound, where the gain moves only once every several windows. A small band around each target leaves the gain alone, so the loop does not hunt between two codes once it has settled.

The log code is 0.05 dB per step. Internally the code is split into a power-of-two shift and a mantissa. The mantissa is built from a 20-entry fine table (0.05 dB steps within one dB) and a 6-entry coarse table (whole dB within one octave). Each octave is taken as 120 codes.

Top module: `snd_agc_loop`

## Requirements
- R1: While reset is asserted, and after it is released, the gain code reads 0x0C8, `out_valid` is 0 and `out_data` is 0 until the first valid sample.
- R2: The gain code g means (g − 200) × 0.05 dB. Code 0x0C8 scales by exactly 1, and each further 120 codes scales by exactly another factor of 2 (120 codes per octave). The result is rounded toward minus infinity. It appears on `out_data` with `out_valid` high on the clock edge after the one that accepts the sample.
- R3: A scaled result outside the signed `OUT_W` range is clamped to the most positive (2047) or most negative (−2048) value at the default width.
- R4: `ref_sel` picks the target peak T = floor(FS × P / 1000), with FS = 2^(OUT_W−1) − 1 and P = 1000, 700, 500, 350 for codes 0, 1, 2, 3.
- R5: Each window holds `WIN_LEN` valid samples (default 1024). At the edge that accepts the last sample of a window, the peak magnitude over that window (last sample included) is compared with the target. The gain rises by one code if the peak is below the band and falls by one code if it is above. At all other times the gain changes only through a host write.
- R6: The band runs from floor(T × 97 / 100) to floor(T × 103 / 100), both ends included. A peak inside the band leaves the gain unchanged. The magnitude of a negative sample is its absolute value.
- R7: With `slow_mode` = 0 the gain may move after every window. With `slow_mode` = 1 it may move only after every `SLOW_DIV`-th window (default 16), counted from reset or from the last host write. Windows in between leave it unchanged.
- R8: The gain stays at 0 when the loop asks for a decrease there, and stays at 0x7FF when it asks for an increase there. It never wraps.
- R9: A host write puts `gain_wr_data` on `gain_code` from the next cycle. The write also restarts the sample window, the window peak and the slow-mode window count, and regulation continues from the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W (16) | Signed input sample |
| ref_sel | input | 2 | Target level select |
| slow_mode | input | 1 | 0: step per window, 1: step per SLOW_DIV windows |
| gain_wr_en | input | 1 | Host gain write strobe |
| gain_wr_data | input | GAIN_W (11) | Gain code to write |
| out_valid | output | 1 | Scaled sample strobe |
| out_data | output | OUT_W (12) | Signed scaled, saturated sample |
| gain_code | output | GAIN_W (11) | Current log gain code |

## Verification
The assertions assume that a host write and a valid sample never fall on the same cycle. They also assume that `ref_sel` and `slow_mode` stay constant within a window, so each gain step can be traced to one window and one target. The stimulus meets these assumptions. It changes the select and mode only between windows, and always issues a gain write before a new measurement. That write restarts the window, so every expected step falls at a known sample count. The tests drive their windows with constant-magnitude samples, so the peak of each window is known exactly and the levels at the edges of the band can be hit one code inside and one code outside.

// File: rtl/snd_agc_pkg.sv
`timescale 1ns/1ps
package snd_agc_pkg;

  localparam int GAIN_UNITY = 200;   // 0 dB code
  localparam int OCT_CODES  = 120;   // codes per factor of two
  localparam int UNITY_OCT  = 2;     // octave index holding the unity code
  localparam int CODE_OFFS  = UNITY_OCT * OCT_CODES - GAIN_UNITY;
  localparam int FRAC       = 14;    // mantissa fraction bits
  localparam int BAND_LO    = 97;    // percent of target
  localparam int BAND_HI    = 103;
  localparam int NUM_LVL    = 4;

  typedef enum logic {LOOP_FAST = 1'b0, LOOP_SLOW = 1'b1} loop_speed_e;

  // 10^(r*0.05/20) in Q14, r = 0..19
  function automatic logic [14:0] fine_step(input logic [4:0] r);
    case (r)
      5'd0:  fine_step = 15'd16384;  5'd1:  fine_step = 15'd16479;
      5'd2:  fine_step = 15'd16574;  5'd3:  fine_step = 15'd16669;
      5'd4:  fine_step = 15'd16766;  5'd5:  fine_step = 15'd16862;
      5'd6:  fine_step = 15'd16960;  5'd7:  fine_step = 15'd17058;
      5'd8:  fine_step = 15'd17156;  5'd9:  fine_step = 15'd17255;
      5'd10: fine_step = 15'd17355;  5'd11: fine_step = 15'd17455;
      5'd12: fine_step = 15'd17556;  5'd13: fine_step = 15'd17657;
      5'd14: fine_step = 15'd17759;  5'd15: fine_step = 15'd17862;
      5'd16: fine_step = 15'd17965;  5'd17: fine_step = 15'd18068;
      5'd18: fine_step = 15'd18173;  5'd19: fine_step = 15'd18278;
      default: fine_step = 15'd16384;
    endcase
  endfunction

  // 10^(d/20) in Q14, d = 0..5
  function automatic logic [14:0] coarse_step(input logic [2:0] d);
    case (d)
      3'd0: coarse_step = 15'd16384;
      3'd1: coarse_step = 15'd18383;
      3'd2: coarse_step = 15'd20626;
      3'd3: coarse_step = 15'd23143;
      3'd4: coarse_step = 15'd25967;
      3'd5: coarse_step = 15'd29135;
      default: coarse_step = 15'd16384;
    endcase
  endfunction

  // target level in per-mille of full scale
  function automatic int level_permil(input int i);
    case (i)
      0: level_permil = 1000;
      1: level_permil = 700;
      2: level_permil = 500;
      default: level_permil = 350;
    endcase
  endfunction

endpackage

// File: rtl/snd_gain_mapper.sv
`timescale 1ns/1ps
module snd_gain_mapper
  import snd_agc_pkg::*;
#(
  parameter int GAIN_W = 11,
  parameter int OCT_W  = 5
) (
  input  logic [GAIN_W-1:0] gain,
  output logic [15:0]       mant,
  output logic [OCT_W-1:0]  oct
);
  localparam int UW = GAIN_W + 1;

  logic [UW-1:0] code_u, oct_full, rem_full;
  logic [6:0]    rem, whole_db, frac_idx;
  logic [31:0]   mprod;

  always_comb begin
    code_u   = {1'b0, gain} + UW'(CODE_OFFS);
    oct_full = code_u / UW'(OCT_CODES);
    rem_full = code_u - oct_full * UW'(OCT_CODES);
    rem      = 7'(rem_full);
    whole_db = rem / 7'd20;
    frac_idx = rem - whole_db * 7'd20;
    mprod    = {17'd0, coarse_step(3'(whole_db))} * {17'd0, fine_step(5'(frac_idx))};
    mant     = 16'(mprod >> FRAC);
    oct      = OCT_W'(oct_full);
  end
endmodule

// File: rtl/snd_scaler.sv
`timescale 1ns/1ps
module snd_scaler
  import snd_agc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 12,
  parameter int OCT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [15:0]              mant,
  input  logic [OCT_W-1:0]         oct,
  output logic signed [OUT_W-1:0]  y_now,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int PW   = DATA_W + 17 + (1 << OCT_W);
  localparam int NORM = FRAC + UNITY_OCT;
  localparam logic signed [PW-1:0] MAXO = PW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINO = ~MAXO;

  logic signed [PW-1:0] prod_w, shifted, scaled;
  logic                 vld_d;
  logic signed [OUT_W-1:0] dat_d;

  always_comb begin
    prod_w  = $signed({{(PW-DATA_W){in_data[DATA_W-1]}}, in_data})
            * $signed({{(PW-16){1'b0}}, mant});
    shifted = prod_w <<< oct;
    scaled  = shifted >>> NORM;
    if (scaled > MAXO)      y_now = OUT_W'(MAXO);
    else if (scaled < MINO) y_now = OUT_W'(MINO);
    else                    y_now = OUT_W'(scaled);
  end

  always_comb begin
    vld_d = in_valid;
    dat_d = in_valid ? y_now : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= dat_d;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("out_valid missing after sample");
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data))) else $error("spurious output");
endmodule

// File: rtl/snd_peak_window.sv
`timescale 1ns/1ps
module snd_peak_window #(
  parameter int OUT_W   = 12,
  parameter int WIN_LEN = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    in_valid,
  input  logic signed [OUT_W-1:0] y_now,
  output logic                    win_done,
  output logic [OUT_W-1:0]        peak_now
);
  localparam int CNT_W = $clog2(WIN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OUT_W-1:0] peak_q, peak_d, mag;

  always_comb begin
    mag      = y_now[OUT_W-1] ? (~y_now + 1'b1) : y_now;
    peak_now = (mag > peak_q) ? mag : peak_q;
    win_done = in_valid && !restart && (cnt_q == LAST);
    cnt_d    = cnt_q;
    peak_d   = peak_q;
    if (restart || win_done) begin
      cnt_d  = '0;
      peak_d = '0;
    end else if (in_valid) begin
      cnt_d  = cnt_q + 1'b1;
      peak_d = peak_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      peak_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      peak_q <= peak_d;
    end
  end

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && peak_q == '0)) else $error("window not restarted");
  assert_window_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (cnt_q == '0)) else $error("window count did not wrap");
endmodule

// File: rtl/snd_gain_ctrl.sv
`timescale 1ns/1ps
module snd_gain_ctrl
  import snd_agc_pkg::*;
#(
  parameter int OUT_W    = 12,
  parameter int GAIN_W   = 11,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_done,
  input  logic [OUT_W-1:0]  peak_now,
  input  logic [1:0]        ref_sel,
  input  loop_speed_e       speed,
  input  logic              wr_en,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int CMP_W = OUT_W + 1;
  localparam int FS    = (2 ** (OUT_W - 1)) - 1;
  localparam int SD_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SD_W-1:0]   SD_LAST = SD_W'(SLOW_DIV - 1);
  localparam logic [GAIN_W-1:0] GMAX    = '1;

  logic [CMP_W-1:0] lo_tab [NUM_LVL];
  logic [CMP_W-1:0] hi_tab [NUM_LVL];

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    localparam int TGT = FS * level_permil(i) / 1000;
    assign lo_tab[i] = CMP_W'(TGT * BAND_LO / 100);
    assign hi_tab[i] = CMP_W'(TGT * BAND_HI / 100);
  end

  logic [CMP_W-1:0]  pk, lo_sel, hi_sel;
  logic              want_up, want_dn, step_en;
  logic [SD_W-1:0]   slow_q, slow_d;
  logic [GAIN_W-1:0] gain_d;

  always_comb begin
    pk      = {1'b0, peak_now};
    lo_sel  = lo_tab[ref_sel];
    hi_sel  = hi_tab[ref_sel];
    want_up = pk < lo_sel;
    want_dn = pk > hi_sel;
    step_en = win_done && ((speed == LOOP_FAST) || (slow_q == SD_LAST));
    gain_d  = gain_q;
    slow_d  = slow_q;
    if (wr_en) begin
      gain_d = wr_data;
      slow_d = '0;
    end else if (win_done) begin
      if (speed == LOOP_FAST || slow_q == SD_LAST) slow_d = '0;
      else                                         slow_d = slow_q + 1'b1;
      if (step_en && want_up && gain_q != GMAX)    gain_d = gain_q + 1'b1;
      else if (step_en && want_dn && gain_q != '0) gain_d = gain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(GAIN_UNITY);
      slow_q <= '0;
    end else begin
      gain_q <= gain_d;
      slow_q <= slow_d;
    end
  end

  assert_host_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (gain_q == $past(wr_data))) else $error("host write lost");
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1
                || gain_q == $past(gain_q) - 1'b1)) else $error("gain jumped");
  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !win_done) |=> $stable(gain_q)) else $error("gain moved mid-window");
  assert_dead_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && win_done && pk >= lo_sel && pk <= hi_sel) |=> $stable(gain_q))
    else $error("gain moved inside band");
  assert_slow_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && win_done && speed == LOOP_SLOW && slow_q != SD_LAST) |=> $stable(gain_q))
    else $error("slow loop stepped early");
  assert_no_wrap_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && gain_q == GMAX) |=> (gain_q != '0)) else $error("gain wrapped up");
  assert_no_wrap_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && gain_q == '0) |=> (gain_q != GMAX)) else $error("gain wrapped down");
endmodule

// File: rtl/snd_agc_loop.sv
`timescale 1ns/1ps
module snd_agc_loop
  import snd_agc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OUT_W    = 12,
  parameter int GAIN_W   = 11,
  parameter int WIN_LEN  = 1024,
  parameter int SLOW_DIV = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [1:0]               ref_sel,
  input  logic                     slow_mode,
  input  logic                     gain_wr_en,
  input  logic [GAIN_W-1:0]        gain_wr_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data,
  output logic [GAIN_W-1:0]        gain_code
);
  localparam int OCT_W = $clog2(((1 << GAIN_W) + CODE_OFFS) / OCT_CODES + 1);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [15:0]             mant;
  logic [OCT_W-1:0]        oct;
  logic signed [OUT_W-1:0] y_now;
  logic                    win_done;
  logic [OUT_W-1:0]        peak_now;
  loop_speed_e             speed;

  assign speed = slow_mode ? LOOP_SLOW : LOOP_FAST;

  snd_gain_mapper #(.GAIN_W(GAIN_W), .OCT_W(OCT_W)) u_map (
    .gain(gain_code), .mant(mant), .oct(oct));

  snd_scaler #(.DATA_W(DATA_W), .OUT_W(OUT_W), .OCT_W(OCT_W)) u_scale (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_data(in_data),
    .mant(mant), .oct(oct), .y_now(y_now), .out_valid(out_valid), .out_data(out_data));

  snd_peak_window #(.OUT_W(OUT_W), .WIN_LEN(WIN_LEN)) u_peak (
    .clk(clk), .rst_n(rst_core_n), .restart(gain_wr_en), .in_valid(in_valid),
    .y_now(y_now), .win_done(win_done), .peak_now(peak_now));

  snd_gain_ctrl #(.OUT_W(OUT_W), .GAIN_W(GAIN_W), .SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .win_done(win_done), .peak_now(peak_now),
    .ref_sel(ref_sel), .speed(speed), .wr_en(gain_wr_en), .wr_data(gain_wr_data),
    .gain_q(gain_code));
endmodule

// File: tb/snd_agc_loop_tb.sv
`timescale 1ns/1ps
module snd_agc_loop_tb;
  localparam int DW = 16, OW = 12, GW = 11, WIN = 32, SDIV = 4, NV = 12;
  localparam int FS = 2047;

  // gain code, input sample, expected output (R2 mapping, R3 clamp)
  localparam int VG [NV] = '{200, 200, 320, 320,  80,   80, 440, 2047, 2047,   560, 200,   320};
  localparam int VX [NV] = '{100,-100, 100,-300, 101, -101, 100,    1,   -1, -1000,   0, 32767};
  localparam int VY [NV] = '{100,-100, 200,-600,  50,  -51, 400, 2047,-2048, -2048,   0,  2047};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, slow_mode = 1'b0, gain_wr_en = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [1:0] ref_sel = 2'd0;
  logic [GW-1:0] gain_wr_data = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;
  logic [GW-1:0] gain_code;
  int n_chk = 0, n_bad = 0;

  snd_agc_loop #(.DATA_W(DW), .OUT_W(OW), .GAIN_W(GW), .WIN_LEN(WIN), .SLOW_DIV(SDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .ref_sel(ref_sel),
    .slow_mode(slow_mode), .gain_wr_en(gain_wr_en), .gain_wr_data(gain_wr_data),
    .out_valid(out_valid), .out_data(out_data), .gain_code(gain_code));

  function automatic int tgt(int sel);
    int p;
    case (sel) 0: p = 1000; 1: p = 700; 2: p = 500; default: p = 350; endcase
    return FS * p / 1000;
  endfunction
  function automatic int lo_of(int sel); return tgt(sel) * 97 / 100;  endfunction
  function automatic int hi_of(int sel); return tgt(sel) * 103 / 100; endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic wr_gain(int g);
    gain_wr_en = 1'b1; gain_wr_data = GW'(g);
    @(negedge clk);
    gain_wr_en = 1'b0;
  endtask
  task automatic push(int x);
    in_valid = 1'b1; in_data = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask
  task automatic windows(int x, int n);
    in_valid = 1'b1; in_data = DW'(x);
    repeat (n * WIN) @(negedge clk);
    in_valid = 1'b0;
  endtask
  task automatic one_window(int sel, int g, int x, int exp, string tag);
    ref_sel = 2'(sel);
    wr_gain(g);
    windows(x, 1);
    chk(tag, int'(gain_code), exp);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gain during reset", int'(gain_code), 200);
    chk("R1 out_valid during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gain after release", int'(gain_code), 200);
    chk("R1 out_data after release", int'(out_data), 0);

    // vector table: R2 mapping and R3 clamp
    for (int i = 0; i < NV; i++) begin
      wr_gain(VG[i]);
      chk("R9 readback", int'(gain_code), VG[i]);
      push(VX[i]);
      chk("R2 out_valid", int'(out_valid), 1);
      chk("R2/R3 out_data", int'(out_data), VY[i]);
    end
    @(negedge clk);
    chk("R2 out_valid drops", int'(out_valid), 0);

    // R5 fast loop up and down, R9 resumes from written code
    slow_mode = 1'b0;
    ref_sel = 2'd0; wr_gain(200);
    windows(100, 1); chk("R5 step up", int'(gain_code), 201);
    windows(100, 1); chk("R5 second step", int'(gain_code), 202);
    one_window(0, 300, 100, 301, "R9 resume from write");
    one_window(3, 320, 400, 319, "R5 step down");
    one_window(3, 200, -800, 199, "R6 negative magnitude");

    // R4 levels and R6 band edges, unity gain so peak = |sample|
    one_window(3, 200, lo_of(3),     200, "R6 lower edge");
    one_window(3, 200, lo_of(3) - 1, 201, "R6 below band");
    one_window(3, 200, hi_of(3),     200, "R6 upper edge");
    one_window(3, 200, hi_of(3) + 1, 199, "R6 above band");
    one_window(0, 200, 2000,         200, "R4 level 0 in band");
    one_window(1, 200, tgt(1),       200, "R4 level 1 in band");
    one_window(1, 200, tgt(3),       201, "R4 level 1 low");
    one_window(2, 200, 1100,         199, "R4 level 2 high");

    // R7 slow loop
    slow_mode = 1'b1; ref_sel = 2'd0;
    wr_gain(200);
    windows(100, SDIV - 1); chk("R7 slow hold", int'(gain_code), 200);
    windows(100, 1);        chk("R7 slow step", int'(gain_code), 201);
    slow_mode = 1'b0;

    // R8 clamps
    one_window(3, 0, 30000, 0, "R8 floor");
    one_window(0, 2047, 0, 2047, "R8 ceiling");

    summary();
  end
endmodule